// File: doc/BRIEF.md
# Edge Interrupt Request Latch with One-Deep Hold

This block latches edge-type interrupt requests for a parameterized number of sources. Each source owns a visible request flag. A single-cycle request pulse sets the flag when it is clear. Software clears the flag with a clear strobe, and a DMA engine clears it with an acceptance acknowledgement.

A request that arrives while its flag is still set is not lost and is not forwarded. It is parked in one hidden slot per source. Any further requests that arrive while that slot is occupied fold into the same entry. When the flag drops, the parked request is issued again: it sets the flag once more and empties the slot. Dropping the source's enable discards the parked entry.

The flag and the hidden slot of every source are brought out as status, so that the backlog can be observed. Arbitration between sources and interrupt vectoring belong to other blocks.

Top module: `irq_hold_buf`

## Requirements
- R1: After reset, every flag bit and every hold bit reads 0.
- R2: A request pulse on a source whose flag is 0 sets that flag at the next clock edge, and its hold bit stays 0.
- R3: A request pulse on a source whose flag is 1 and is not being cleared leaves the flag at 1. If the source's enable is 1, the pulse sets the hold bit at the next edge.
- R4: Further pulses while the hold bit is already 1 merge into that entry. A single clear then leaves the flag at 1 with the hold bit at 0, and a second clear returns the flag to 0.
- R5: Clearing a flag whose hold bit is 1 (enable 1, no new pulse) re-issues the held request: at the next edge the flag reads 1 and the hold bit reads 0.
- R6: Clearing a flag whose hold bit is 0, with no pulse in the same cycle, makes the flag read 0 at the next edge.
- R7: The software clear strobe and the DMA acknowledge have the same effect, whether asserted alone or together.
- R8: A clear and a pulse in the same cycle with the hold bit at 0 leave the flag at 1 and the hold bit at 0.
- R9: A clear and a pulse in the same cycle with the hold bit at 1 (enable 1) leave the flag at 1 and the hold bit at 1.
- R10: In any cycle where a source's enable is 0, its hold bit is 0 at the next edge. A pulse that arrives while the flag is 1 and the enable is 0 is dropped. The flag itself is not changed by the enable.
- R11: Each source's flag and hold bit depend only on that source's own inputs.
- R12: A hold bit is never 1 while the flag of the same source is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | NSRC | Single-cycle request pulse, one bit per source |
| sw_clr | input | NSRC | Software strobe that writes 0 to the flag, one bit per source |
| dma_ack | input | NSRC | DMA acceptance acknowledge that clears the flag, one bit per source |
| src_en | input | NSRC | Peripheral enable level per source; 0 discards the held request |
| flag | output | NSRC | Visible request flag per source |
| pend | output | NSRC | Hidden hold bit per source |

## Verification
The assertions take the inputs as known, synchronous values that are sampled once per rising edge, with no constraint on how inputs combine. This is why a clear, a pulse and a dropped enable in the same cycle each have a defined outcome. The bench changes inputs only one time unit after a rising edge and holds each strobe for exactly one cycle. It reads the outputs one time unit after the following edge, so every expected value is the result of exactly one register update.

// File: rtl/irq_hold_buf.sv
module irq_hold_buf #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_pulse,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] dma_ack,
  input  logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] clr, held, flag_live, flag_d, pend_d;

  assign clr       = sw_clr | dma_ack;
  assign held      = pend & src_en;
  assign flag_live = flag & ~clr;

  // While the flag survives, new pulses pile into the hold slot.
  // Once it drops, the held entry wins the flag and a fresh pulse takes its place.
  assign flag_d = flag_live | held | req_pulse;
  assign pend_d = flag_live ? ((held | req_pulse) & src_en)
                            : (held & req_pulse & src_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      pend <= '0;
    end else begin
      flag <= flag_d;
      pend <= pend_d;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r12_pend_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |-> flag[i]);

    a_r2_set_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && req_pulse[i]) |=> (flag[i] && !pend[i]));

    a_r3_retain_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !sw_clr[i] && !dma_ack[i] && req_pulse[i] && src_en[i])
      |=> (flag[i] && pend[i]));

    a_r4_merge_keeps_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !sw_clr[i] && !dma_ack[i] && src_en[i]) |=> (flag[i] && pend[i]));

    a_r5_reissue_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && (sw_clr[i] || dma_ack[i]) && src_en[i] && !req_pulse[i])
      |=> (flag[i] && !pend[i]));

    a_r6_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[i] && (sw_clr[i] || dma_ack[i]) && !req_pulse[i]) |=> !flag[i]);

    a_r9_clear_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && (sw_clr[i] || dma_ack[i]) && src_en[i] && req_pulse[i])
      |=> (flag[i] && pend[i]));

    a_r10_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[i] |=> !pend[i]);
  end

endmodule

// File: tb/irq_hold_buf_test.sv
module irq_hold_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_pulse = '0, sw_clr = '0, dma_ack = '0, src_en = '1;
  logic [N-1:0] flag, pend;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hold_buf #(.NSRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .sw_clr(sw_clr),
    .dma_ack(dma_ack), .src_en(src_en), .flag(flag), .pend(pend)
  );

  task automatic expect_state(input string tag, input logic [N-1:0] ef, input logic [N-1:0] ep);
    checks++;
    if (flag !== ef || pend !== ep) begin
      failures++;
      $display("FAIL %s: flag=%b pend=%b expected flag=%b pend=%b", tag, flag, pend, ef, ep);
    end
  endtask

  task automatic cyc(input logic [N-1:0] rq, input logic [N-1:0] sc, input logic [N-1:0] da);
    req_pulse = rq; sw_clr = sc; dma_ack = da;
    @(posedge clk); #1;
    req_pulse = '0; sw_clr = '0; dma_ack = '0;
  endtask

  task automatic t_reset;
    expect_state("R1 reset", 4'b0000, 4'b0000);
  endtask

  task automatic t_set_retain_merge;
    cyc(4'b0001, 0, 0); expect_state("R2 set from idle", 4'b0001, 4'b0000);
    cyc(4'b0001, 0, 0); expect_state("R3 retain while set", 4'b0001, 4'b0001);
    cyc(4'b0001, 0, 0); expect_state("R4 merge second pulse", 4'b0001, 4'b0001);
    cyc(0, 4'b0001, 0); expect_state("R5 reissue on clear", 4'b0001, 4'b0000);
    cyc(0, 4'b0001, 0); expect_state("R4 R6 second clear idles", 4'b0000, 4'b0000);
  endtask

  task automatic t_dma;
    cyc(4'b0010, 0, 0); cyc(4'b0010, 0, 0);
    cyc(0, 0, 4'b0010); expect_state("R7 dma reissue", 4'b0010, 4'b0000);
    cyc(0, 0, 4'b0010); expect_state("R7 dma clear", 4'b0000, 4'b0000);
    cyc(4'b0010, 0, 0);
    cyc(0, 4'b0010, 4'b0010); expect_state("R7 both clears", 4'b0000, 4'b0000);
  endtask

  task automatic t_clear_with_pulse;
    cyc(4'b0100, 0, 0);
    cyc(4'b0100, 4'b0100, 0); expect_state("R8 clear+pulse empty hold", 4'b0100, 4'b0000);
    cyc(4'b0100, 0, 0);
    cyc(4'b0100, 4'b0100, 0); expect_state("R9 clear+pulse held", 4'b0100, 4'b0100);
    cyc(0, 4'b0100, 0); cyc(0, 4'b0100, 0);
    expect_state("R6 drained", 4'b0000, 4'b0000);
  endtask

  task automatic t_enable;
    cyc(4'b1000, 0, 0); cyc(4'b1000, 0, 0);
    expect_state("R3 held before disable", 4'b1000, 4'b1000);
    src_en = 4'b0111;
    cyc(0, 0, 0); expect_state("R10 disable flushes", 4'b1000, 4'b0000);
    cyc(4'b1000, 0, 0); expect_state("R10 pulse dropped while disabled", 4'b1000, 4'b0000);
    src_en = 4'b1111;
    cyc(0, 4'b1000, 0); expect_state("R10 clear after flush idles", 4'b0000, 4'b0000);
  endtask

  task automatic t_independent;
    cyc(4'b0011, 0, 0); cyc(4'b0001, 0, 0);
    expect_state("R11 only source0 holds", 4'b0011, 4'b0001);
    cyc(0, 4'b0010, 0); expect_state("R11 clear source1 only", 4'b0001, 4'b0001);
    cyc(0, 4'b0001, 0); cyc(0, 4'b0001, 0);
    expect_state("R11 R12 all idle", 4'b0000, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_set_retain_merge();
    t_dma();
    t_clear_with_pulse();
    t_enable();
    t_independent();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule